// File: doc/BRIEF.md
# 66-Bit Block Alignment Finder

This block takes a one-bit-per-cycle stream of scrambled 64B/66B line bits, qualified by a valid strobe, and finds where each 66-bit block begins. Every block starts with a two-bit header. A legal header always has its two bits different, while any other pair of adjacent bits in the scrambled payload differs only about half the time. A wrong boundary guess therefore soon lands on a header of `00` or `11`. When that happens while hunting, the block drops one incoming bit, which moves its framing one bit later, and tries again.

Each completed 66-bit window is presented with a one-cycle strobe and a header class of data, control or invalid. The data and control codes differ in both bits, so no single bit error can turn one into the other. A small state machine with two states, `ST_HUNT` and `ST_LOCKED`, tracks alignment. `ST_HUNT` moves to `ST_LOCKED` (transition *acquire*) after 64 valid headers in a row at one offset. `ST_LOCKED` moves to `ST_HUNT` (transition *lose*) when 16 invalid headers fall inside one 64-block window. Windows are counted from the first block after lock. In every other case the state holds (*hunt-stay* / *lock-stay*).

Top module: `blk66_aligner`

## Requirements
- R1: A synchronous active-high reset clears `locked` and `blk_vld`, and framing restarts at offset 0: the first 66 valid bits after reset form the first block.
- R2: The first bit received of a block appears at `blk_out[65]` and the last at `blk_out[0]`. The header is `blk_out[65:64]`. `blk_vld` is high in the cycle after the 66th valid bit is sampled.
- R3: `hdr_kind` is `01` (data) for header `01`, `10` (control) for header `10`, and `00` (invalid) for headers `00` and `11`.
- R4: Cycles with `line_vld` low are ignored: the bits on `line_bit` in those cycles never enter a block.
- R5: In `ST_HUNT`, a block with an invalid header causes the next incoming valid bit to be discarded, so the following block starts one bit later.
- R6: `locked` rises in the cycle after the strobe of the 64th consecutive valid header in `ST_HUNT`, and not after the 63rd.
- R7: In `ST_LOCKED`, `locked` falls in the cycle after the strobe of the 16th invalid header within one window; 15 invalid headers keep lock.
- R8: The invalid-header count is cleared every 64 blocks while locked, so invalid headers in earlier windows do not add up.
- R9: `blk_vld` is a single-cycle pulse, and it is raised only in a cycle after a valid line bit has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Serial line bit, first received bit first |
| line_vld | input | 1 | Qualifies `line_bit` in this cycle |
| blk_out | output | 66 | Last completed block, header in bits 65:64 |
| hdr_kind | output | 2 | Header class: 01 data, 10 control, 00 invalid |
| blk_vld | output | 1 | One-cycle strobe for a new `blk_out` |
| locked | output | 1 | High while in `ST_LOCKED` |

## Verification
A wrong bit counter or a lost slip shows at the ports within one block time. The payload and header on `blk_out` shift against the expected stream, and `hdr_kind` starts reporting invalid where data or control was sent. A miscounting lock or window counter shows only at the acquire and lose thresholds. For that reason the bench probes `locked` one block before and exactly at each threshold: the 63rd and 64th valid headers, the 15th and 16th invalid headers, and the window boundary.

// File: rtl/blk66_pkg.sv
package blk66_pkg;

    // Header classification reported on the block output
    typedef enum logic [1:0] {
        KIND_INV  = 2'b00,
        KIND_DATA = 2'b01,
        KIND_CTRL = 2'b10
    } hdr_kind_e;

    // Alignment state
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_e;

endpackage

// File: rtl/blk66_shifter.sv
// Serial-to-block assembly with a one-bit slip control.
module blk66_shifter #(
    parameter int PAY_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_in,
    input  logic               bit_vld,
    input  logic               slip,
    output logic [PAY_W+1:0]   blk_out,
    output logic               blk_stb
);
    localparam int BLK_W = PAY_W + 2;
    localparam int CW    = $clog2(BLK_W);
    localparam logic [CW-1:0] LAST = CW'(BLK_W - 1);

    logic [BLK_W-2:0] sr;
    logic [CW-1:0]    cnt;
    logic             slip_pend;
    logic             skip;

    assign skip = slip | slip_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            cnt       <= '0;
            slip_pend <= 1'b0;
            blk_out   <= '0;
            blk_stb   <= 1'b0;
        end else begin
            blk_stb <= 1'b0;
            if (bit_vld) begin
                if (skip) begin
                    // drop this bit: framing moves one position later
                    slip_pend <= 1'b0;
                end else begin
                    sr <= {sr[BLK_W-3:0], bit_in};
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        blk_out <= {sr, bit_in};
                        blk_stb <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else if (slip) begin
                slip_pend <= 1'b1;
            end
        end
    end

    // R9
    blk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blk_stb |=> !blk_stb);

    // R9
    blk_src_chk: assert property (@(posedge clk) disable iff (rst)
        blk_stb |-> $past(bit_vld));

endmodule

// File: rtl/blk66_hdr_sort.sv
// Two-bit header classifier.
module blk66_hdr_sort
    import blk66_pkg::*;
(
    input  logic [1:0] hdr,
    output hdr_kind_e  kind
);
    always_comb begin
        unique case (hdr)
            2'b01:   kind = KIND_DATA;
            2'b10:   kind = KIND_CTRL;
            default: kind = KIND_INV;
        endcase
    end
endmodule

// File: rtl/blk66_sync_fsm.sv
// Hunt / lock state machine with acquire and loss counters.
module blk66_sync_fsm
    import blk66_pkg::*;
#(
    parameter int LOCK_N = 64,
    parameter int BAD_N  = 16,
    parameter int WIN_N  = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      blk_stb,
    input  hdr_kind_e kind,
    output logic      slip,
    output logic      locked
);
    localparam int GW = $clog2(LOCK_N + 1);
    localparam int BW = $clog2(BAD_N + 1);
    localparam int WW = $clog2(WIN_N + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_N - 1);
    localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_N - 1);
    localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_N - 1);

    sync_state_e     state, state_nxt;
    logic [GW-1:0]   good_cnt;
    logic [BW-1:0]   bad_cnt;
    logic [WW-1:0]   win_cnt;
    logic            hdr_ok;

    assign hdr_ok = (kind != KIND_INV);

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (blk_stb && hdr_ok && good_cnt == GOOD_LAST)
                    state_nxt = ST_LOCKED;          // acquire
            end
            ST_LOCKED: begin
                if (blk_stb && !hdr_ok && bad_cnt == BAD_LAST)
                    state_nxt = ST_HUNT;            // lose
            end
            default: state_nxt = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= state_nxt;
    end

    // counters
    always_ff @(posedge clk) begin
        if (rst) begin
            good_cnt <= '0;
            bad_cnt  <= '0;
            win_cnt  <= '0;
        end else if (blk_stb) begin
            if (state_nxt != state) begin
                good_cnt <= '0;
                bad_cnt  <= '0;
                win_cnt  <= '0;
            end else if (state == ST_HUNT) begin
                good_cnt <= hdr_ok ? good_cnt + 1'b1 : '0;
            end else if (win_cnt == WIN_LAST) begin
                win_cnt <= '0;
                bad_cnt <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (!hdr_ok) bad_cnt <= bad_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        locked = (state == ST_LOCKED);
        slip   = blk_stb && !hdr_ok &&
                 (state == ST_HUNT || state_nxt == ST_HUNT);
    end

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(blk_stb && kind != KIND_INV));

    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(blk_stb && kind == KIND_INV));

    // R5
    slip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        slip |-> (blk_stb && kind == KIND_INV));

endmodule

// File: rtl/blk66_aligner.sv
// Top: 66-bit block alignment finder.
module blk66_aligner
    import blk66_pkg::*;
#(
    parameter int PAY_W  = 64,
    parameter int LOCK_N = 64,
    parameter int BAD_N  = 16,
    parameter int WIN_N  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_bit,
    input  logic             line_vld,
    output logic [PAY_W+1:0] blk_out,
    output logic [1:0]       hdr_kind,
    output logic             blk_vld,
    output logic             locked
);
    logic      slip;
    hdr_kind_e kind;

    blk66_shifter #(.PAY_W(PAY_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (line_bit),
        .bit_vld (line_vld),
        .slip    (slip),
        .blk_out (blk_out),
        .blk_stb (blk_vld)
    );

    blk66_hdr_sort u_sort (
        .hdr  (blk_out[PAY_W+1:PAY_W]),
        .kind (kind)
    );

    blk66_sync_fsm #(
        .LOCK_N (LOCK_N),
        .BAD_N  (BAD_N),
        .WIN_N  (WIN_N)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .blk_stb (blk_vld),
        .kind    (kind),
        .slip    (slip),
        .locked  (locked)
    );

    assign hdr_kind = kind;

    // R3
    data_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_vld && hdr_kind == 2'b01) |-> blk_out[PAY_W+1:PAY_W] == 2'b01);

    // R3
    ctrl_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_vld && hdr_kind == 2'b10) |-> blk_out[PAY_W+1:PAY_W] == 2'b10);

endmodule

// File: tb/sim_blk66_aligner.sv
module sim_blk66_aligner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_bit = 1'b0;
    logic        line_vld = 1'b0;
    logic [65:0] blk_out;
    logic [1:0]  hdr_kind;
    logic        blk_vld;
    logic        locked;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [65:0] d;
        logic [1:0]  k;
        bit          dchk;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

    always #4 clk = ~clk;   // 125 MHz

    blk66_aligner u0 (
        .clk(clk), .rst(rst), .line_bit(line_bit), .line_vld(line_vld),
        .blk_out(blk_out), .hdr_kind(hdr_kind), .blk_vld(blk_vld),
        .locked(locked)
    );

    function automatic logic [1:0] kind_of(input logic [1:0] h);
        if (h == 2'b01)      return 2'b01;
        else if (h == 2'b10) return 2'b10;
        else                 return 2'b00;
    endfunction

    task automatic next_pay(output logic [63:0] p);
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
        p = lfsr;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, act, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        line_bit = b;
        line_vld = 1'b1;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_vld = 1'b0;
            line_bit = 1'b1;
        end
    endtask

    // Driver: pushes the expected item and shifts the block out
    task automatic send_block(input logic [1:0] h, input logic [63:0] p,
                              input bit push, input string tag,
                              input int gap_at);
        exp_t e;
        logic [65:0] w;
        w = {h, p};
        if (push) begin
            e.d = w; e.k = kind_of(h); e.dchk = 1'b1; e.tag = tag;
            q.push_back(e);
        end
        for (int i = 65; i >= 0; i--) begin
            if (i == gap_at) gap(3);
            send_bit(w[i]);
        end
    endtask

    task automatic check_lock(input logic expv, input string tag);
        gap(2);
        check(locked == expv, tag, "locked", int'(locked), int'(expv));
    endtask

    task automatic do_reset;
        rst = 1'b1;
        line_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compares each produced block with the scoreboard
    always @(negedge clk) begin
        if (!rst && blk_vld) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected block", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(hdr_kind == e.k, e.tag, "hdr_kind",
                      int'(hdr_kind), int'(e.k));
                if (e.dchk)
                    check(blk_out == e.d, e.tag, "block low word",
                          int'(blk_out[31:0]), int'(e.d[31:0]));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] p;
        logic [1:0]  h;
        exp_t e;

        // ---- R1: reset state
        do_reset();
        @(negedge clk);
        check(locked == 1'b0, "R1", "locked after reset", int'(locked), 0);
        check(blk_vld == 1'b0, "R1", "blk_vld after reset", int'(blk_vld), 0);

        // ---- aligned stream from offset 0: R2 R3 R4 R6 R9
        next_pay(p);
        send_block(2'b10, p, 1'b1, "R2", -1);
        @(negedge clk); line_vld = 1'b0;
        check(blk_vld == 1'b1, "R2", "strobe after 66th bit", int'(blk_vld), 1);
        @(negedge clk);
        check(blk_vld == 1'b0, "R9", "strobe width", int'(blk_vld), 0);
        for (int i = 1; i < 64; i++) begin
            next_pay(p);
            h = (i % 3 == 0) ? 2'b10 : 2'b01;
            send_block(h, p, 1'b1, (i == 10) ? "R4" : "R3",
                       (i == 10) ? 40 : -1);
            if (i == 62) check_lock(1'b0, "R6");
        end
        check_lock(1'b1, "R6");

        // ---- window 1: 15 invalid then 49 valid, keep lock (R7 R8)
        for (int i = 0; i < 64; i++) begin
            next_pay(p);
            h = (i < 15) ? ((i % 2 == 0) ? 2'b00 : 2'b11) : 2'b01;
            send_block(h, p, 1'b1, "R3", -1);
        end
        check_lock(1'b1, "R7");
        // ---- window 2: another 15 invalid, counts must not add up (R8)
        for (int i = 0; i < 64; i++) begin
            next_pay(p);
            h = (i < 15) ? 2'b11 : 2'b10;
            send_block(h, p, 1'b1, "R8", -1);
            if (i == 14) check_lock(1'b1, "R8");
        end
        check_lock(1'b1, "R8");
        // ---- window 3: 16 invalid, lock lost (R7)
        for (int i = 0; i < 16; i++) begin
            next_pay(p);
            send_block(2'b00, p, 1'b1, "R7", -1);
            if (i == 14) check_lock(1'b1, "R7");
        end
        check_lock(1'b0, "R7");
        check(q.size() == 0, "R2", "queue drained", q.size(), 0);

        // ---- hunt from a misaligned start: R1 R5 R6
        do_reset();
        for (int i = 0; i < 3; i++) begin
            e.d = '0; e.k = 2'b00; e.dchk = 1'b0; e.tag = "R5";
            q.push_back(e);
        end
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        for (int i = 0; i < 67; i++) begin
            next_pay(p);
            p[1:0] = 2'b00;
            send_block(2'b01, p, (i >= 3), "R5", -1);
            if (i == 65) check_lock(1'b0, "R6");
        end
        check_lock(1'b1, "R6");
        gap(4);
        check(q.size() == 0, "R5", "queue drained", q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule